// File: doc/BRIEF.md
# Fractionally Trimmed Periodic Tick Generator

The block derives a periodic tick from a fast master clock. A divider forms a slow timing step of seven master cycles, and a down counter spaces ticks by a programmable number of slow steps. The ideal period is often not a whole number of slow steps. A phase accumulator holds the leftover fraction, counted in master cycles. On each tick it adds a small correction modulo seven. When that addition wraps, one later period can be stretched by one slow step, so the average period is trimmed in sevenths of a slow step.

A two-bit mode input sets who makes the stretch decision. Hardware can apply the stretch on its own, or software can grant it with an adjust write. The mode also sets when the sticky interrupt is raised. A timemark output marks every Nth tick. It is delayed by the accumulator value from before that tick's calculation, in master cycles, plus half a master cycle, so downstream logic sees a pulse that is aligned in fine time.

Top module: `tick_trim_gen`

## Requirements
- R1: During and after reset, until the first tick, `tick_o`, `irq_o`, `adj_status_o` and `timemark_o` are 0 and `phase_o` is 0.
- R2: `tick_o` is a one-cycle pulse. Without a stretch, successive ticks are `(reload_i+1)*7` master cycles apart.
- R3: In any mode other than 00, each tick adds `corr_i` to the phase. A sum of 7 or more counts as overflow and wraps by subtracting 7. The new phase appears on `phase_o` one master cycle after `tick_o`, and `phase_o` changes at no other time.
- R4: In mode 00 (`mode_i` = 2'b00) the phase holds, no interrupt is raised, no period is stretched, and `adj_status_o` reads 0 from the cycle after the mode is entered.
- R5: In mode 01 an overflow stretches the following period by 7 master cycles. The interrupt is raised after every calculation, and `adj_status_o` shows the overflow result. Status and interrupt change two master cycles after `tick_o`.
- R6: In mode 01, adjust writes have no effect on period length or status.
- R7: In mode 10, the interrupt and `adj_status_o` are set only by an overflowing calculation. A period is stretched only if an adjust write of 1 arrives before it ends, and that write clears `adj_status_o`.
- R8: In mode 11, the interrupt is raised after every calculation, and `adj_status_o` shows that calculation's overflow. A stretch needs an adjust write of 1, and that write clears `adj_status_o`.
- R9: In modes 10 and 11, an adjust write with `adj_wd_i` = 0 changes nothing. A write of 1 stretches the next period even when `adj_status_o` is 0.
- R10: `irq_o` stays set until a cycle with `irq_clr_i` high. It falls only in the cycle after such a request.
- R11: A timemark is produced on a tick once the ticks counted since the previous mark (or reset) reach `mark_div_i`. A value of 0 acts as 1. Each mark is one master cycle wide.
- R12: A timemark rises half a master cycle after the clock edge that comes `2+d` cycles after the edge that raises `tick_o`. Here `d` is the value of `phase_o` during the tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | CNT_W | Tick period minus one, in slow steps |
| corr_i | input | PH_W | Phase correction added per tick |
| mode_i | input | 2 | 00 off, 01 hardware, 10 software on overflow, 11 software always |
| mark_div_i | input | DIV_W | Ticks per timemark (0 acts as 1) |
| adj_we_i | input | 1 | Adjust write strobe |
| adj_wd_i | input | 1 | Adjust write data |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| tick_o | output | 1 | One-cycle tick pulse |
| phase_o | output | PH_W | Current phase offset |
| irq_o | output | 1 | Sticky interrupt flag |
| adj_status_o | output | 1 | Stretch-suggested status bit |
| timemark_o | output | 1 | Delayed timemark pulse |

## Verification
The checks assume that `mode_i` and `corr_i` change only between calculations, never in the two cycles right after a tick. They also assume that adjust writes never land in the cycle where a period ends, so a request is never set and consumed in the same cycle. The stimulus changes configuration only about eleven cycles after a tick, and it issues writes three to five cycles after a tick. `reload_i` is kept at 1 or more, so each period outlasts the longest timemark delay. The bench measures tick spacing, phase, status, interrupt and timemark timing against its own model of the accumulator, through all four modes.

// File: rtl/tick_trim_pkg.sv
`timescale 1ns/100ps
package tick_trim_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_HW     = 2'b01,
    MODE_SW_OVF = 2'b10,
    MODE_SW_ALL = 2'b11
  } trim_mode_e;
endpackage

// File: rtl/tt_slow_div.sv
`timescale 1ns/100ps
module tt_slow_div #(
  parameter int unsigned SLOW_DIV = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slow_en_o
);
  localparam int unsigned W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [W-1:0] cnt_q;
  wire last = (cnt_q == W'(SLOW_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign slow_en_o = last;
endmodule

// File: rtl/tt_period_ctr.sv
`timescale 1ns/100ps
module tt_period_ctr #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ext_req_i,
  output logic             consume_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  wire at_end = slow_en_i && (cnt_q == '0);

  // an extension request turns one reload into a one-step hold
  assign consume_o = at_end && ext_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= at_end && !ext_req_i;
      if (slow_en_i) begin
        if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
        else if (ext_req_i) cnt_q <= '0;
        else                cnt_q <= reload_i;
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tt_phase_ctl.sv
`timescale 1ns/100ps
module tt_phase_ctl
  import tick_trim_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 7,
  parameter int unsigned PH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [1:0]      mode_i,
  input  logic [PH_W-1:0] corr_i,
  input  logic            adj_we_i,
  input  logic            adj_wd_i,
  input  logic            irq_clr_i,
  input  logic            consume_i,
  output logic [PH_W-1:0] phase_o,
  output logic            irq_o,
  output logic            status_o,
  output logic            ext_req_o
);
  localparam int unsigned SW = PH_W + 1;

  trim_mode_e mode;
  assign mode = trim_mode_e'(mode_i);

  logic [PH_W-1:0] phase_q;
  logic            calc_q, ovf_q, irq_q, status_q, ext_q;
  logic [SW-1:0]   sum, wrap;
  logic            ovf;
  logic [PH_W-1:0] phase_nxt;

  always_comb begin
    sum       = {1'b0, phase_q} + {1'b0, corr_i};
    wrap      = sum - SW'(SLOW_DIV);
    ovf       = (sum >= SW'(SLOW_DIV));
    phase_nxt = ovf ? wrap[PH_W-1:0] : sum[PH_W-1:0];
  end

  wire active   = (mode != MODE_OFF);
  wire sw_mode  = (mode == MODE_SW_OVF) || (mode == MODE_SW_ALL);
  wire adj_hit  = adj_we_i && adj_wd_i && sw_mode;
  wire irq_set  = calc_q && ((mode == MODE_HW) || (mode == MODE_SW_ALL) || ovf_q);
  wire hw_ext   = calc_q && ovf_q && (mode == MODE_HW);

  // calculation stage: phase and overflow land one cycle after the tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      calc_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      calc_q <= tick_i && active;
      if (tick_i && active) begin
        phase_q <= phase_nxt;
        ovf_q   <= ovf;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
    end else if (!active) begin
      status_q <= 1'b0;
    end else if (calc_q) begin
      if (mode == MODE_SW_OVF) begin
        if (ovf_q) status_q <= 1'b1;
      end else begin
        status_q <= ovf_q;
      end
    end else if (adj_hit) begin
      status_q <= 1'b0;
    end
  end

  // a fresh request wins over consumption in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ext_q <= 1'b0;
    else if (hw_ext || adj_hit) ext_q <= 1'b1;
    else if (consume_i)        ext_q <= 1'b0;
  end

  assign phase_o   = phase_q;
  assign irq_o     = irq_q;
  assign status_o  = status_q;
  assign ext_req_o = ext_q;
endmodule

// File: rtl/tt_mark_gen.sv
`timescale 1ns/100ps
module tt_mark_gen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [DIV_W-1:0] mark_div_i,
  output logic             timemark_o
);
  logic [DIV_W-1:0] mcnt_q;
  logic [PH_W-1:0]  dly_q;
  logic             arm_q, pos_q, neg_q;

  wire [DIV_W:0] seen = {1'b0, mcnt_q} + 1'b1;
  wire           fire = tick_i && (seen >= {1'b0, mark_div_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= '0;
      dly_q  <= '0;
      arm_q  <= 1'b0;
      pos_q  <= 1'b0;
    end else begin
      pos_q <= 1'b0;
      if (tick_i) mcnt_q <= fire ? '0 : seen[DIV_W-1:0];
      if (fire) begin
        arm_q <= 1'b1;
        dly_q <= phase_i;
      end else if (arm_q) begin
        if (dly_q == '0) begin
          pos_q <= 1'b1;
          arm_q <= 1'b0;
        end else begin
          dly_q <= dly_q - 1'b1;
        end
      end
    end
  end

  // half-cycle retiming on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= pos_q;
  end

  assign timemark_o = neg_q;
endmodule

// File: rtl/tick_trim_gen.sv
`timescale 1ns/100ps
module tick_trim_gen #(
  parameter int unsigned SLOW_DIV = 7,
  parameter int unsigned PH_W     = 3,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned DIV_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [PH_W-1:0]  corr_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] mark_div_i,
  input  logic             adj_we_i,
  input  logic             adj_wd_i,
  input  logic             irq_clr_i,
  output logic             tick_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             irq_o,
  output logic             adj_status_o,
  output logic             timemark_o
);
  logic slow_en, ext_req, consume, tick;
  logic [PH_W-1:0] phase;

  tt_slow_div #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_en_o (slow_en)
  );

  tt_period_ctr #(.CNT_W(CNT_W)) u_per (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_en_i (slow_en),
    .reload_i  (reload_i),
    .ext_req_i (ext_req),
    .consume_o (consume),
    .tick_o    (tick)
  );

  tt_phase_ctl #(.SLOW_DIV(SLOW_DIV), .PH_W(PH_W)) u_ph (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode_i),
    .corr_i    (corr_i),
    .adj_we_i  (adj_we_i),
    .adj_wd_i  (adj_wd_i),
    .irq_clr_i (irq_clr_i),
    .consume_i (consume),
    .phase_o   (phase),
    .irq_o     (irq_o),
    .status_o  (adj_status_o),
    .ext_req_o (ext_req)
  );

  tt_mark_gen #(.DIV_W(DIV_W), .PH_W(PH_W)) u_mark (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .phase_i    (phase),
    .mark_div_i (mark_div_i),
    .timemark_o (timemark_o)
  );

  assign tick_o  = tick;
  assign phase_o = phase;
endmodule

// File: rtl/tick_trim_gen_chk.sv
`timescale 1ns/100ps
module tick_trim_gen_chk #(
  parameter int unsigned SLOW_DIV = 7,
  parameter int unsigned PH_W     = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic            irq_clr_i,
  input logic            tick_o,
  input logic [PH_W-1:0] phase_o,
  input logic            irq_o,
  input logic            adj_status_o,
  input logic            timemark_o
);
  // R2
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R3
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_o) |-> $stable(phase_o));

  // R3
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PH_W'(SLOW_DIV));

  // R4
  off_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> !adj_status_o);

  // R7
  ovf_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && mode_i == 2'b10) |-> adj_status_o);

  // R10
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i));

  // R11
  mark_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timemark_o |=> !timemark_o);
endmodule

bind tick_trim_gen tick_trim_gen_chk #(.SLOW_DIV(SLOW_DIV), .PH_W(PH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .irq_clr_i    (irq_clr_i),
  .tick_o       (tick_o),
  .phase_o      (phase_o),
  .irq_o        (irq_o),
  .adj_status_o (adj_status_o),
  .timemark_o   (timemark_o)
);

// File: tb/tick_trim_gen_tb_top.sv
`timescale 1ns/100ps
module tick_trim_gen_tb_top;
  localparam int CNT_W = 20;
  localparam int DIV_W = 8;
  localparam int PH_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CNT_W-1:0] reload = 3;
  logic [PH_W-1:0]  corr = 0;
  logic [1:0]       mode = 0;
  logic [DIV_W-1:0] ndiv = 2;
  logic adj_we = 0, adj_wd = 0, irq_clr = 0;
  logic tick_o, irq_o, adj_status_o, timemark_o;
  logic [PH_W-1:0] phase_o;

  tick_trim_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .corr_i(corr),
    .mode_i(mode), .mark_div_i(ndiv), .adj_we_i(adj_we), .adj_wd_i(adj_wd),
    .irq_clr_i(irq_clr), .tick_o(tick_o), .phase_o(phase_o), .irq_o(irq_o),
    .adj_status_o(adj_status_o), .timemark_o(timemark_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  longint cyc = 0, tick_cyc = 0, tm_cyc = 0;
  int tick_cnt = 0, tm_cnt = 0, tm_wide = 0;
  bit tm_prev = 0;
  int    ival_q[$];
  string tag_q[$];
  int    exp_iv;
  string exp_tag;

  // model state
  int ph = 0, since_mark = 0;
  bit st = 0, irq_m = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  // monitor: pops expected tick spacing, records timemarks
  initial begin
    forever begin
      @(posedge clk); #4;
      cyc++;
      if (tick_o) begin
        if (tick_cnt > 0 && ival_q.size() > 0) begin
          exp_iv  = ival_q.pop_front();
          exp_tag = tag_q.pop_front();
          chk(cyc - tick_cyc == exp_iv, exp_tag, cyc - tick_cyc, exp_iv);
        end
        tick_cyc = cyc;
        tick_cnt++;
      end
      if (timemark_o && !tm_prev) begin tm_cnt++; tm_cyc = cyc; end
      if (timemark_o && tm_prev) tm_wide++;
      tm_prev = timemark_o;
    end
  end

  // driver: wr 0 none, 1 write one, 2 write zero
  task automatic handle(int wr, bit clr, string tag);
    int seen, d, sum, nph, at, tm0, need;
    bit ovf, stretch, mark, irq_set;
    longint tc;
    seen = tick_cnt;
    wait (tick_cnt != seen);
    tc  = tick_cyc;
    tm0 = tm_cnt;
    d   = ph;
    if (mode != 0) begin
      sum = ph + corr;
      ovf = (sum >= 7);
      nph = ovf ? sum - 7 : sum;
    end else begin
      ovf = 0;
      nph = ph;
    end
    need = (ndiv == 0) ? 1 : int'(ndiv);
    since_mark++;
    mark = (since_mark >= need);
    if (mark) since_mark = 0;
    case (mode)
      2'b00: st = 0;
      2'b10: if (ovf) st = 1;
      default: st = ovf;
    endcase
    irq_set = (mode == 1) || (mode == 3) || (mode == 2 && ovf);
    if (irq_set) irq_m = 1;
    if (mode == 1)      stretch = ovf;
    else if (mode >= 2) stretch = (wr == 1);
    else                stretch = 0;
    ival_q.push_back((int'(reload) + 1 + int'(stretch)) * 7);
    tag_q.push_back({tag, " spacing"});

    wait_cyc(3); at = 3;
    chk(phase_o == nph[PH_W-1:0], "R3 phase", phase_o, nph);
    chk(irq_o == irq_m, {tag, " irq"}, irq_o, irq_m);
    chk(adj_status_o == st, {tag, " status"}, adj_status_o, st);
    ph = nph;
    if (wr != 0) begin
      @(posedge clk); #1 adj_we = 1; adj_wd = (wr == 1);
      @(posedge clk); #1 adj_we = 0; adj_wd = 0;
      at += 2;
      if (mode >= 2 && wr == 1) st = 0;
    end
    if (clr) begin
      @(posedge clk); #1 irq_clr = 1;
      @(posedge clk); #1 irq_clr = 0;
      at += 2;
      irq_m = 0;
    end
    wait_cyc(11 - at);
    chk(adj_status_o == st, {tag, " status after write"}, adj_status_o, st);
    chk(irq_o == irq_m, "R10 irq after clear", irq_o, irq_m);
    if (mark) begin
      chk(tm_cnt == tm0 + 1, "R11 mark count", tm_cnt, tm0 + 1);
      chk(tm_cyc - tc == 2 + d, "R12 mark delay", tm_cyc - tc, 2 + d);
    end else begin
      chk(tm_cnt == tm0, "R11 no mark", tm_cnt, tm0);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1 during reset
    chk(!tick_o && !irq_o && !adj_status_o && !timemark_o, "R1 reset outputs", 
        {tick_o, irq_o, adj_status_o, timemark_o}, 0);
    chk(phase_o == 0, "R1 reset phase", phase_o, 0);
    @(posedge clk); #1 rst_n = 1;
    wait_cyc(2);
    chk(!tick_o && !irq_o && !adj_status_o && phase_o == 0, "R1 after release",
        {tick_o, irq_o, adj_status_o, phase_o}, 0);

    // mode 00, R2 base spacing, R4 phase hold
    handle(0, 0, "R2");
    handle(0, 0, "R2");
    corr = 5;
    handle(0, 0, "R4");
    handle(1, 0, "R4");

    // mode 01, corr 4: 4 1 5 2 6 3
    mode = 1; corr = 4;
    handle(0, 1, "R5");
    handle(0, 1, "R5");
    handle(0, 1, "R5");
    handle(0, 1, "R5");
    handle(1, 1, "R6");
    handle(1, 1, "R6");

    // mode 10, corr 3 from 3: 6 2 5 1 4 0
    mode = 2; corr = 3;
    handle(0, 1, "R7");
    handle(1, 1, "R7");
    handle(0, 1, "R7");
    handle(2, 0, "R9");
    handle(0, 1, "R10");
    handle(1, 1, "R9");

    // mode 11, corr 5 from 0: 5 3 1 6
    mode = 3; corr = 5;
    handle(0, 1, "R8");
    handle(1, 1, "R8");
    handle(1, 1, "R8");
    handle(2, 1, "R9");

    // shorter period, mark every tick
    reload = 1; ndiv = 0; mode = 1; corr = 2;
    handle(0, 1, "R11");
    handle(0, 1, "R11");
    handle(0, 1, "R11");
    handle(0, 1, "R2");

    ndiv = 3;
    mode = 0;
    handle(0, 0, "R4");
    handle(0, 0, "R4");
    handle(0, 0, "R4");

    wait_cyc(5);
    chk(tm_wide == 0, "R11 mark width", tm_wide, 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule